// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a module clock into the bit-level time base of a CAN node. A programmable divider cuts the clock into time quanta. A sequencer then walks every bit through three parts: a one-quantum synchronisation slot, a combined propagation-and-first-phase stretch, and a second-phase stretch. Two single-cycle strobes come out of it. One marks the sample point, which is the end of the first stretch. The other marks the bit boundary, which is the end of the second stretch. Frame logic further up the chip uses these strobes to sample and drive the bus.

Software configures the block through a small write/read register port. The control register holds a halt bit and a configuration-unlock bit. The timing register and the divider-extension register only change while both of those bits are set. While halted, the block stops and waits.

After the halt is released, the block idles until it sees the first falling edge on the receive line. That edge is a hard synchronisation and starts a bit. From then on, each falling edge nudges the bit timing. An edge that arrives late in the first stretch lengthens it. An edge that arrives early, in the second stretch, shortens that stretch. Each correction is capped by the programmed jump width. The receive line is only looked at on quantum ticks. The register port is a control interface, so it has no flow control, and the strobes are plain pulses that cannot be held off.

Top module: `can_bit_timer`

## Requirements
- R1: After reset, control reads 0x0001 (halted, locked), the timing register reads 0x0100, the extension register reads 0x0000, and both strobes stay low.
- R2: Register addresses are 0 for control (bit 0 halt, bit 1 unlock), 1 for timing and 2 for extension. The timing register holds second phase minus one in bits 14:12, propagation-plus-first-phase minus one in bits 11:8, jump width minus one in bits 7:6, and the low divider bits in 5:0. The extension register holds divider bits 9:6 in its bits 3:0. Bits that are not implemented read as zero.
- R3: A write to timing or extension takes effect only if, before that write, both halt and unlock were set. Otherwise the write is dropped and the read-back value does not change.
- R4: One quantum lasts {extension, divider field} + 1 clocks, which gives 1 to 1024 clocks.
- R5: A bit with no edges lasts 1 + T1 + T2 quanta, where T1 and T2 are the first-stretch and second-phase field values plus one. The sample strobe comes T2 quanta before the bit strobe.
- R6: A first-stretch field of 0 is treated as 2 quanta.
- R7: While halt is set, the divider and the sequencer are held in reset and no strobes occur. After halt is cleared, the programmed timing is still in place and the block waits for a hard synchronisation.
- R8: While idle, a falling receive edge seen at a quantum tick makes that quantum the synchronisation slot. The sample strobe follows T1 quanta later. No strobes occur while idle.
- R9: A falling edge in the first stretch, in its n-th quantum (n starts at 1), lengthens that stretch by min(n, jump width).
- R10: A falling edge in the second phase, with r quanta left including the current one, shortens it by min(r, jump width). If the shortened length has already elapsed, the phase ends on that quantum.
- R11: Each strobe is one clock wide, and the two strobes are never high in the same cycle.
- R12: The receive line is sampled only on quantum ticks, so a low pulse that falls entirely between two ticks causes no synchronisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read data of the addressed register (combinational) |
| rx_in | input | 1 | Receive line level, 1 is recessive |
| sample_stb | output | 1 | Sample-point pulse |
| bit_stb | output | 1 | Bit-boundary pulse |

## Verification
A register write appears on cfg_rdata in the cycle after the write edge. A change to the halt bit stops or releases the divider at the following edge. Each strobe rises one clock after the quantum tick that ends its segment. The bench drives inputs and samples outputs on the falling edge. It measures every expected delay by counting falling edges from the stimulus to the strobe, and it compares both strobes against a behavioural reference model on every cycle.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;

  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_TIMING = 2'd1;
  localparam logic [1:0] REG_EXT    = 2'd2;

endpackage

// File: rtl/can_bt_regs.sv
module can_bt_regs
  import can_bt_pkg::*;
#(
  parameter int DW    = 16,
  parameter int BRP_W = 6,
  parameter int EXT_W = 4,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             halt,
  output logic [BRP_W-1:0] brp,
  output logic [EXT_W-1:0] ext,
  output logic [TS1_W-1:0] ts1,
  output logic [TS2_W-1:0] ts2,
  output logic [SJW_W-1:0] sjw
);

  localparam int SJW_LO = BRP_W;
  localparam int TS1_LO = SJW_LO + SJW_W;
  localparam int TS2_LO = TS1_LO + TS1_W;
  localparam int BT_W   = TS2_LO + TS2_W;
  localparam logic [BT_W-1:0] BT_RST = BT_W'(1) << TS1_LO;

  logic            halt_q, unlock_q;
  logic [BT_W-1:0] bt_q;
  logic [EXT_W-1:0] ext_q;
  logic            cfg_open;
  logic            unused_hi;

  assign cfg_open  = halt_q && unlock_q;
  assign unused_hi = ^wdata[DW-1:BT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q   <= 1'b1;
      unlock_q <= 1'b0;
      bt_q     <= BT_RST;
      ext_q    <= '0;
    end else if (wr_en) begin
      if (addr == REG_CTRL) begin
        halt_q   <= wdata[0];
        unlock_q <= wdata[1];
      end else if (addr == REG_TIMING && cfg_open) begin
        bt_q <= wdata[BT_W-1:0];
      end else if (addr == REG_EXT && cfg_open) begin
        ext_q <= wdata[EXT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == REG_CTRL)        rdata = DW'({unlock_q, halt_q});
    else if (addr == REG_TIMING) rdata = DW'(bt_q);
    else if (addr == REG_EXT)    rdata = DW'(ext_q);
  end

  assign halt = halt_q;
  assign brp  = bt_q[SJW_LO-1:0];
  assign sjw  = bt_q[TS1_LO-1:SJW_LO];
  assign ts1  = bt_q[TS2_LO-1:TS1_LO];
  assign ts2  = bt_q[BT_W-1:TS2_LO];
  assign ext  = ext_q;

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(bt_q) && $stable(ext_q))); // R3

endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] divm1,
  output logic         tick
);

  logic [W-1:0] cnt_q;

  assign tick = run && (cnt_q == divm1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divm1 != '0) |=> !tick); // R4

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= divm1)); // R4

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             rx,
  input  logic [TS1_W-1:0] ts1_f,
  input  logic [TS2_W-1:0] ts2_f,
  input  logic [SJW_W-1:0] sjw_f,
  output logic             sample_stb,
  output logic             bit_stb
);

  localparam int CW = ((TS1_W > TS2_W) ? TS1_W : TS2_W) + 2;

  seg_e          seg_q;
  logic [CW-1:0] qcnt_q, adj1_q, adj2_q;
  logic          idle_q, rx_q;

  logic [CW-1:0] t1, t2, sj, q1, e1, rem2, e2, len1, len2;
  logic          fall_seen;

  assign t1   = (ts1_f == '0) ? CW'(2) : CW'(ts1_f) + CW'(1);
  assign t2   = CW'(ts2_f) + CW'(1);
  assign sj   = CW'(sjw_f) + CW'(1);
  assign q1   = qcnt_q + CW'(1);
  assign e1   = (q1 < sj) ? q1 : sj;
  assign rem2 = t2 - qcnt_q;
  assign e2   = (rem2 < sj) ? rem2 : sj;

  // receive line looked at only on quantum ticks
  assign fall_seen = tick && rx_q && !rx;

  assign len1 = t1 + (fall_seen ? e1 : adj1_q);
  assign len2 = t2 - (fall_seen ? e2 : adj2_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q      <= SEG_SYNC;
      qcnt_q     <= '0;
      adj1_q     <= '0;
      adj2_q     <= '0;
      idle_q     <= 1'b1;
      rx_q       <= 1'b1;
      sample_stb <= 1'b0;
      bit_stb    <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      bit_stb    <= 1'b0;
      if (!run) begin
        seg_q  <= SEG_SYNC;
        qcnt_q <= '0;
        adj1_q <= '0;
        adj2_q <= '0;
        idle_q <= 1'b1;
        rx_q   <= 1'b1;
      end else if (tick) begin
        rx_q <= rx;
        if (idle_q) begin
          if (fall_seen) begin
            idle_q <= 1'b0;
            seg_q  <= SEG_TS1;
            qcnt_q <= '0;
          end
        end else begin
          case (seg_q)
            SEG_SYNC: begin
              seg_q  <= SEG_TS1;
              qcnt_q <= '0;
            end
            SEG_TS1: begin
              if (fall_seen) adj1_q <= e1;
              if (q1 >= len1) begin
                seg_q      <= SEG_TS2;
                qcnt_q     <= '0;
                sample_stb <= 1'b1;
              end else begin
                qcnt_q <= q1;
              end
            end
            SEG_TS2: begin
              if (fall_seen) adj2_q <= e2;
              if (q1 >= len2) begin
                seg_q   <= SEG_SYNC;
                qcnt_q  <= '0;
                adj1_q  <= '0;
                adj2_q  <= '0;
                bit_stb <= 1'b1;
              end else begin
                qcnt_q <= q1;
              end
            end
            default: seg_q <= SEG_SYNC;
          endcase
        end
      end
    end
  end

  AST_SYNC_ONE_QUANTUM: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_SYNC) |-> (qcnt_q == '0)); // R5
  AST_SAMPLE_OPENS_TS2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (seg_q == SEG_TS2)); // R5
  AST_BIT_OPENS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> (seg_q == SEG_SYNC)); // R5
  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_stb)); // R11
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sample_stb && !bit_stb && idle_q)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q |=> (!sample_stb && !bit_stb)); // R8
  AST_TS1_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_TS1) |-> (qcnt_q < t1 + sj)); // R9
  AST_TS2_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_TS2) |-> (qcnt_q < t2)); // R10

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int DW    = 16,
  parameter int BRP_W = 6,
  parameter int EXT_W = 4,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          rx_in,
  output logic          sample_stb,
  output logic          bit_stb
);

  localparam int DIV_W = BRP_W + EXT_W;

  logic             halt, run, tick;
  logic [BRP_W-1:0] brp;
  logic [EXT_W-1:0] ext;
  logic [TS1_W-1:0] ts1;
  logic [TS2_W-1:0] ts2;
  logic [SJW_W-1:0] sjw;

  assign run = !halt;

  can_bt_regs #(
    .DW(DW), .BRP_W(BRP_W), .EXT_W(EXT_W),
    .TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .halt(halt),
    .brp(brp), .ext(ext), .ts1(ts1), .ts2(ts2), .sjw(sjw)
  );

  can_bt_prescaler #(.W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run),
    .divm1({ext, brp}), .tick(tick)
  );

  can_bt_seq #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .rx(rx_in),
    .ts1_f(ts1), .ts2_f(ts2), .sjw_f(sjw),
    .sample_stb(sample_stb), .bit_stb(bit_stb)
  );

endmodule

// File: tb/can_bit_timer_bench.sv
`timescale 1ns/1ps
module can_bit_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        rx_in = 1'b1;
  logic        sample_stb, bit_stb;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_in(rx_in),
    .sample_stb(sample_stb), .bit_stb(bit_stb)
  );

  // behavioural reference model
  int m_halt, m_unl, m_bt, m_ext, m_pc, m_seg, m_q, m_a1, m_a2, m_idle, m_rxq;
  int m_samp, m_bit;

  always @(posedge clk) begin
    int div, t1f, t1, t2, sj, q1, e, len, open;
    bit tk, fall;
    if (!rst_n) begin
      m_halt = 1; m_unl = 0; m_bt = 'h100; m_ext = 0; m_pc = 0;
      m_seg = 0; m_q = 0; m_a1 = 0; m_a2 = 0; m_idle = 1; m_rxq = 1;
      m_samp = 0; m_bit = 0;
    end else begin
      div = ((m_ext << 6) | (m_bt & 63)) + 1;
      t1f = (m_bt >> 8) & 15;
      t1  = (t1f == 0) ? 2 : t1f + 1;
      t2  = ((m_bt >> 12) & 7) + 1;
      sj  = ((m_bt >> 6) & 3) + 1;
      m_samp = 0; m_bit = 0;
      if (m_halt != 0) begin
        m_pc = 0; m_seg = 0; m_q = 0; m_a1 = 0; m_a2 = 0; m_idle = 1; m_rxq = 1;
      end else begin
        tk = (m_pc == div - 1);
        if (tk) begin
          fall = (m_rxq == 1) && (rx_in == 1'b0);
          q1 = m_q + 1;
          if (m_idle != 0) begin
            if (fall) begin m_idle = 0; m_seg = 1; m_q = 0; end
          end else if (m_seg == 0) begin
            m_seg = 1; m_q = 0;
          end else if (m_seg == 1) begin
            if (fall) m_a1 = (q1 < sj) ? q1 : sj;
            len = t1 + m_a1;
            if (q1 >= len) begin m_seg = 2; m_q = 0; m_samp = 1; end
            else m_q = q1;
          end else begin
            if (fall) begin e = t2 - m_q; m_a2 = (e < sj) ? e : sj; end
            len = t2 - m_a2;
            if (q1 >= len) begin m_seg = 0; m_q = 0; m_a1 = 0; m_a2 = 0; m_bit = 1; end
            else m_q = q1;
          end
          m_rxq = rx_in;
          m_pc = 0;
        end else begin
          m_pc = m_pc + 1;
        end
      end
      open = (m_halt != 0) && (m_unl != 0);
      if (cfg_wr) begin
        if (cfg_addr == 2'd0) begin m_halt = cfg_wdata[0]; m_unl = cfg_wdata[1]; end
        else if (cfg_addr == 2'd1 && open != 0) m_bt = cfg_wdata & 16'h7fff;
        else if (cfg_addr == 2'd2 && open != 0) m_ext = cfg_wdata & 16'h000f;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R5, R11)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(sample_stb == m_samp[0], "R5 sample strobe vs model", sample_stb, m_samp);
      chk(bit_stb == m_bit[0], "R5 bit strobe vs model", bit_stb, m_bit);
      chk(!(sample_stb && bit_stb), "R11 strobes exclusive", sample_stb & bit_stb, 0);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
    @(negedge clk); cfg_addr = a; #1;
    chk(cfg_rdata == exp[15:0], req, cfg_rdata, exp);
  endtask

  task automatic quiet(input int n, input string req);
    int bad = 0;
    repeat (n) begin @(negedge clk); if (sample_stb || bit_stb) bad++; end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic to_sample(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_stb);
  endtask

  task automatic to_bit(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!bit_stb);
  endtask

  task automatic hsync();
    int n;
    rx_in = 1'b0; to_sample(n); rx_in = 1'b1;
  endtask

  // from a bit strobe, pull rx low at negedge k (k=0: same negedge), count to next bit
  task automatic bit_with_fall(input int k, output int n);
    n = 0;
    if (k == 0) rx_in = 1'b0;
    do begin
      @(negedge clk); n++;
      if (n == k) rx_in = 1'b0;
    end while (!bit_stb);
    rx_in = 1'b1;
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    rd_chk(2'd0, 1, "R1 control reset");
    rd_chk(2'd1, 'h0100, "R1 timing reset");
    rd_chk(2'd2, 0, "R1 extension reset");
    quiet(10, "R1 no strobes after reset");

    wr(2'd1, 16'h1234);
    rd_chk(2'd1, 'h0100, "R3 timing write while locked");
    wr(2'd2, 16'h0005);
    rd_chk(2'd2, 0, "R3 extension write while locked");

    wr(2'd0, 16'h0003);
    rd_chk(2'd0, 3, "R2 control bits");
    wr(2'd1, 16'h9440);
    rd_chk(2'd1, 'h1440, "R2 timing fields, bit 15 reads zero");
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);
    rd_chk(2'd1, 'h1440, "R3 timing write while running");

    quiet(20, "R8 idle before first edge");
    @(negedge clk); rx_in = 1'b0;
    to_sample(n); rx_in = 1'b1;
    chk(n == 6, "R8 hard sync to sample", n, 6);
    to_bit(n);  chk(n == 2, "R5 sample to bit equals phase 2", n, 2);
    to_bit(n);  chk(n == 8, "R5 nominal bit length", n, 8);

    bit_with_fall(1, n); chk(n == 9, "R9 ts1 lengthen unclipped", n, 9);
    bit_with_fall(3, n); chk(n == 10, "R9 ts1 lengthen clipped to jump width", n, 10);
    to_bit(n);  chk(n == 8, "R5 nominal after resync", n, 8);

    wr(2'd0, 16'h0001);
    quiet(50, "R7 no strobes while halted");
    rd_chk(2'd1, 'h1440, "R7 timing kept while halted");
    wr(2'd0, 16'h0000);
    quiet(30, "R7 waits for hard sync after release");
    hsync();
    to_bit(n); to_bit(n);
    chk(n == 8, "R7 same bit length after release", n, 8);

    wr(2'd0, 16'h0003); wr(2'd1, 16'h5380); wr(2'd0, 16'h0000);
    hsync();
    to_bit(n); chk(n == 6, "R5 sample to bit, long phase 2", n, 6);
    to_bit(n); chk(n == 11, "R5 bit length, second setting", n, 11);
    to_sample(n);
    rx_in = 1'b0; to_bit(n); rx_in = 1'b1;
    chk(n == 3, "R10 phase 2 shortened by jump width", n, 3);
    to_sample(n);
    n = 0;
    do begin @(negedge clk); n++; if (n == 4) rx_in = 1'b0; end while (!bit_stb);
    rx_in = 1'b1;
    chk(n == 5, "R10 phase 2 ends at elapsed quantum", n, 5);

    wr(2'd0, 16'h0003); wr(2'd1, 16'h0000); wr(2'd0, 16'h0000);
    hsync();
    to_bit(n); to_bit(n);
    chk(n == 4, "R6 zero first-stretch field means 2 quanta", n, 4);

    wr(2'd0, 16'h0003); wr(2'd1, 16'h1442); wr(2'd0, 16'h0000);
    hsync();
    to_bit(n); to_bit(n);
    chk(n == 24, "R4 divider of 3", n, 24);

    wr(2'd0, 16'h0003); wr(2'd1, 16'h0100); wr(2'd2, 16'h0001);
    rd_chk(2'd2, 1, "R4 extension readback");
    wr(2'd0, 16'h0000);
    hsync();
    to_bit(n); to_bit(n);
    chk(n == 260, "R4 divider of 65 using extension", n, 260);

    n = 0;
    rx_in = 1'b0;
    do begin
      @(negedge clk); n++;
      if (n == 3) rx_in = 1'b1;
    end while (!bit_stb);
    chk(n == 260, "R12 low pulse between ticks ignored", n, 260);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule